// File: doc/BRIEF.md
# Asymmetric-Step Loadable Up/Down Counter

This block is a fully synchronous modulo-512 counter whose step size depends on direction: an increment request adds three, a decrement request subtracts five. With neither request raised it takes a parallel value from its data input. With both requests raised it holds its count. The control encoding is the reverse of the usual loadable counter, where loading is the active case.

Three status flags are registered on the same edge as the count. The even-parity flag is the XOR of all nine bits of the new count, so the count plus this flag always holds an even number of ones. The high-wrap flag reports that an increment went past 511. The low-wrap flag reports that a decrement went below 0. A synchronous active-high reset clears the count and all three flags.

Top module: `asym_step_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count and all three flags become 0 at that edge.
- R2: With `inc_req`=0 and `dec_req`=0 (control code 00), the count takes `load_val` at the next rising edge. Both wrap flags are 0 after that edge.
- R3: With `inc_req`=1 and `dec_req`=0 (code 10), the next count is (count + 3) mod 512.
- R4: With `inc_req`=0 and `dec_req`=1 (code 01), the next count is (count − 5) mod 512.
- R5: With both requests at 1 (code 11), the count keeps its value and both wrap flags are 0. The `load_val` input has no effect in this case.
- R6: After every edge, `even_par_q` equals the XOR of all nine bits of `cnt_q`. For example, 0x1FF gives 1 and 0x000 gives 0.
- R7: `wrap_hi_q` is 1 after an edge only if that edge took an increment from a count of 509 or more. It is 0 after every other edge.
- R8: `wrap_lo_q` is 1 after an edge only if that edge took a decrement from a count of 4 or less. It is 0 after every other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all state |
| rst | input | 1 | Synchronous active-high reset |
| inc_req | input | 1 | Increment request (bit 1 of the control code) |
| dec_req | input | 1 | Decrement request (bit 0 of the control code) |
| load_val | input | 9 | Parallel value taken on code 00 |
| cnt_q | output | 9 | Registered count |
| even_par_q | output | 1 | Registered even-parity bit of the count |
| wrap_hi_q | output | 1 | Registered increment wrap flag |
| wrap_lo_q | output | 1 | Registered decrement wrap flag |

## Verification
Every flag is recomputed from scratch on each edge, but the count carries forward. A wrong step constant or a wrong mux arm shows on `cnt_q` one edge after the faulty control code is applied. It then stays wrong until the next load, so the bench loads known values often and checks after every single edge. A flag that decodes the wrong control case, or tests the wrong threshold, is wrong for exactly one cycle. For that reason the wrap thresholds are probed on both sides: counts 508 and 509 for increments, and counts 4 and 5 for decrements. The hold case is checked with `load_val` set to a value that differs from the held count, so a hold that wrongly loads would be caught.

// File: rtl/ucd_pkg.sv
package ucd_pkg;

    // Default geometry of the counter
    localparam int unsigned DEF_WIDTH   = 9;
    localparam int unsigned DEF_UP_STEP = 3;
    localparam int unsigned DEF_DN_STEP = 5;

    // Control code formed as {inc_req, dec_req}
    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_DEC  = 2'b01,
        OP_INC  = 2'b10,
        OP_HOLD = 2'b11
    } step_op_e;

    // Status flags registered alongside the count
    typedef struct packed {
        logic parity;
        logic wrap_hi;
        logic wrap_lo;
    } flags_t;

    localparam flags_t FLAGS_CLEAR = '{parity: 1'b0, wrap_hi: 1'b0, wrap_lo: 1'b0};

    function automatic step_op_e decode_op(input logic inc, input logic dec);
        return step_op_e'({inc, dec});
    endfunction

endpackage

// File: rtl/ucd_step_arith.sv
// One directional stepper: adds or subtracts a constant and reports the
// bit shifted out above the count width.
module ucd_step_arith #(
    parameter int unsigned W      = ucd_pkg::DEF_WIDTH,
    parameter int unsigned STEP   = ucd_pkg::DEF_UP_STEP,
    parameter bit          ADD    = 1'b1
) (
    input  logic [W-1:0] operand,
    output logic [W-1:0] result,
    output logic         wrap
);
    localparam int unsigned EW = W + 1;
    localparam logic [EW-1:0] STEP_EXT = EW'(STEP);

    logic [EW-1:0] ext;

    generate
        if (ADD) begin : g_add
            assign ext = {1'b0, operand} + STEP_EXT;
        end else begin : g_sub
            assign ext = {1'b0, operand} - STEP_EXT;
        end
    endgenerate

    assign result = ext[W-1:0];
    assign wrap   = ext[W];
endmodule

// File: rtl/ucd_next_sel.sv
// Chooses the next count and the next flag values from the control code.
module ucd_next_sel
    import ucd_pkg::*;
#(
    parameter int unsigned W = DEF_WIDTH
) (
    input  step_op_e     op,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] par_in,
    input  logic [W-1:0] inc_res,
    input  logic         inc_wrap,
    input  logic [W-1:0] dec_res,
    input  logic         dec_wrap,
    output logic [W-1:0] nxt,
    output flags_t       nxt_flags
);
    always_comb begin
        nxt               = cur;
        nxt_flags         = FLAGS_CLEAR;
        unique case (op)
            OP_LOAD: nxt = par_in;
            OP_DEC: begin
                nxt               = dec_res;
                nxt_flags.wrap_lo = dec_wrap;
            end
            OP_INC: begin
                nxt               = inc_res;
                nxt_flags.wrap_hi = inc_wrap;
            end
            OP_HOLD: nxt = cur;
            default: nxt = cur;
        endcase
        nxt_flags.parity = ^nxt;
    end
endmodule

// File: rtl/ucd_state_reg.sv
// Count and flag storage with synchronous active-high clear.
module ucd_state_reg
    import ucd_pkg::*;
#(
    parameter int unsigned W = DEF_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_cnt,
    input  flags_t       d_flags,
    output logic [W-1:0] q_cnt,
    output flags_t       q_flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_cnt   <= '0;
            q_flags <= FLAGS_CLEAR;
        end else begin
            q_cnt   <= d_cnt;
            q_flags <= d_flags;
        end
    end
endmodule

// File: rtl/asym_step_counter.sv
module asym_step_counter
    import ucd_pkg::*;
#(
    parameter int unsigned W       = DEF_WIDTH,
    parameter int unsigned UP_STEP = DEF_UP_STEP,
    parameter int unsigned DN_STEP = DEF_DN_STEP
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_req,
    input  logic         dec_req,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q,
    output logic         even_par_q,
    output logic         wrap_hi_q,
    output logic         wrap_lo_q
);
    step_op_e     op;
    logic [W-1:0] inc_res, dec_res, nxt;
    logic         inc_wrap, dec_wrap;
    flags_t       nxt_flags, flags_q;

    assign op = decode_op(inc_req, dec_req);

    ucd_step_arith #(.W(W), .STEP(UP_STEP), .ADD(1'b1)) u_inc (
        .operand (cnt_q),
        .result  (inc_res),
        .wrap    (inc_wrap)
    );

    ucd_step_arith #(.W(W), .STEP(DN_STEP), .ADD(1'b0)) u_dec (
        .operand (cnt_q),
        .result  (dec_res),
        .wrap    (dec_wrap)
    );

    ucd_next_sel #(.W(W)) u_sel (
        .op        (op),
        .cur       (cnt_q),
        .par_in    (load_val),
        .inc_res   (inc_res),
        .inc_wrap  (inc_wrap),
        .dec_res   (dec_res),
        .dec_wrap  (dec_wrap),
        .nxt       (nxt),
        .nxt_flags (nxt_flags)
    );

    ucd_state_reg #(.W(W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .d_cnt   (nxt),
        .d_flags (nxt_flags),
        .q_cnt   (cnt_q),
        .q_flags (flags_q)
    );

    assign even_par_q = flags_q.parity;
    assign wrap_hi_q  = flags_q.wrap_hi;
    assign wrap_lo_q  = flags_q.wrap_lo;
endmodule

// File: rtl/ucd_counter_chk.sv
module ucd_counter_chk #(
    parameter int unsigned W       = 9,
    parameter int unsigned UP_STEP = 3,
    parameter int unsigned DN_STEP = 5
) (
    input logic         clk,
    input logic         rst,
    input logic         inc_req,
    input logic         dec_req,
    input logic [W-1:0] load_val,
    input logic [W-1:0] cnt_q,
    input logic         even_par_q,
    input logic         wrap_hi_q,
    input logic         wrap_lo_q
);
    localparam logic [W-1:0] HI_LIM = W'((1 << W) - UP_STEP);
    localparam logic [W-1:0] LO_LIM = W'(DN_STEP);

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!inc_req && !dec_req) |=> (cnt_q == $past(load_val)));

    // R3
    inc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (inc_req && !dec_req) |=> (cnt_q == W'($past(cnt_q) + UP_STEP)));

    // R4
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!inc_req && dec_req) |=> (cnt_q == W'($past(cnt_q) - DN_STEP)));

    // R5
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (inc_req && dec_req) |=> ($stable(cnt_q) && !wrap_hi_q && !wrap_lo_q));

    // R6
    parity_match_chk: assert property (@(posedge clk) disable iff (rst)
        even_par_q == ^cnt_q);

    // R7
    wrap_hi_set_chk: assert property (@(posedge clk) disable iff (rst)
        (inc_req && !dec_req) |=> (wrap_hi_q == ($past(cnt_q) >= HI_LIM)));

    // R7
    wrap_hi_other_chk: assert property (@(posedge clk) disable iff (rst)
        !(inc_req && !dec_req) |=> !wrap_hi_q);

    // R8
    wrap_lo_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!inc_req && dec_req) |=> (wrap_lo_q == ($past(cnt_q) < LO_LIM)));

    // R8
    wrap_lo_other_chk: assert property (@(posedge clk) disable iff (rst)
        !(!inc_req && dec_req) |=> !wrap_lo_q);
endmodule

bind asym_step_counter ucd_counter_chk #(
    .W(W), .UP_STEP(UP_STEP), .DN_STEP(DN_STEP)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .inc_req    (inc_req),
    .dec_req    (dec_req),
    .load_val   (load_val),
    .cnt_q      (cnt_q),
    .even_par_q (even_par_q),
    .wrap_hi_q  (wrap_hi_q),
    .wrap_lo_q  (wrap_lo_q)
);

// File: tb/sim_asym_step_counter.sv
`timescale 1ns/1ps
module sim_asym_step_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       inc_req = 1'b0;
    logic       dec_req = 1'b0;
    logic [8:0] load_val = '0;
    logic [8:0] cnt_q;
    logic       even_par_q, wrap_hi_q, wrap_lo_q;

    int checks = 0;
    int errors = 0;

    // reference state
    int   m_cnt = 0;
    logic m_par = 1'b0, m_hi = 1'b0, m_lo = 1'b0;

    always #2.5 clk = ~clk;

    asym_step_counter u0 (
        .clk(clk), .rst(rst), .inc_req(inc_req), .dec_req(dec_req),
        .load_val(load_val), .cnt_q(cnt_q), .even_par_q(even_par_q),
        .wrap_hi_q(wrap_hi_q), .wrap_lo_q(wrap_lo_q)
    );

    function automatic logic par9(input int v);
        logic [8:0] b = 9'(v);
        return ^b;
    endfunction

    task automatic model_step(input logic i, input logic d, input logic [8:0] v);
        m_hi = 1'b0;
        m_lo = 1'b0;
        if (!i && !d) m_cnt = int'(v);
        else if (i && !d) begin
            m_hi  = (m_cnt + 3) > 511;
            m_cnt = (m_cnt + 3) % 512;
        end else if (!i && d) begin
            m_lo  = m_cnt < 5;
            m_cnt = (m_cnt + 512 - 5) % 512;
        end
        m_par = par9(m_cnt);
    endtask

    task automatic check(input string req);
        checks++;
        if (cnt_q !== 9'(m_cnt) || even_par_q !== m_par ||
            wrap_hi_q !== m_hi || wrap_lo_q !== m_lo) begin
            errors++;
            $display("FAIL %s: cnt/par/hi/lo actual %0d/%b/%b/%b expected %0d/%b/%b/%b",
                     req, cnt_q, even_par_q, wrap_hi_q, wrap_lo_q,
                     m_cnt, m_par, m_hi, m_lo);
        end
    endtask

    // Starts and ends at a falling edge
    task automatic step(input logic i, input logic d, input logic [8:0] v, input string req);
        inc_req  = i;
        dec_req  = d;
        load_val = v;
        model_step(i, d, v);
        @(posedge clk);
        @(negedge clk);
        check(req);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        m_cnt = 0; m_par = 0; m_hi = 0; m_lo = 0;
        @(posedge clk);
        @(negedge clk);
        check("R1");
        rst = 1'b0;
    endtask

    task automatic t_load();
        step(0, 0, 9'h1FF, "R2 load all ones, R6 parity 1");
        step(0, 0, 9'h000, "R2 load zero, R6 parity 0");
        step(0, 0, 9'h155, "R2 load 0x155, R6");
        step(0, 0, 9'h0F0, "R2 load 0x0F0, R6");
    endtask

    task automatic t_inc();
        step(0, 0, 9'd10, "R2 preset");
        for (int k = 0; k < 4; k++) step(1, 0, 9'h0AA, "R3 increment");
        step(0, 0, 9'd510, "R2 preset 510");
        step(1, 0, 9'd0, "R3 R7 510 wraps to 1 with carry");
        step(1, 0, 9'd0, "R7 carry clears on next increment");
    endtask

    task automatic t_dec();
        step(0, 0, 9'd100, "R2 preset");
        for (int k = 0; k < 4; k++) step(0, 1, 9'h055, "R4 decrement");
        step(0, 0, 9'd2, "R2 preset 2");
        step(0, 1, 9'd0, "R4 R8 2 wraps to 509 with borrow");
        step(0, 1, 9'd0, "R8 borrow clears");
    endtask

    task automatic t_hold();
        step(0, 0, 9'd77, "R2 preset");
        step(1, 1, 9'd300, "R5 hold ignores load_val");
        step(1, 1, 9'h1FF, "R5 hold again");
        step(0, 0, 9'd510, "R2 preset 510");
        step(1, 0, 9'd0, "R7 carry set");
        step(1, 1, 9'd0, "R5 R7 hold clears carry");
        step(0, 1, 9'd0, "R4");
        step(0, 0, 9'd1, "R2 preset 1");
        step(0, 1, 9'd0, "R8 borrow set");
        step(0, 0, 9'd5, "R2 R8 load clears borrow");
    endtask

    task automatic t_edges();
        step(0, 0, 9'd508, "R2 preset 508");
        step(1, 0, 9'd0, "R7 508 to 511 no carry");
        step(0, 0, 9'd509, "R2 preset 509");
        step(1, 0, 9'd0, "R7 509 to 0 carry");
        step(0, 0, 9'd5, "R2 preset 5");
        step(0, 1, 9'd0, "R8 5 to 0 no borrow");
        step(0, 0, 9'd4, "R2 preset 4");
        step(0, 1, 9'd0, "R8 4 to 511 borrow");
        step(0, 0, 9'd0, "R2 preset 0");
        step(0, 1, 9'd0, "R4 R8 0 to 507 borrow");
    endtask

    task automatic t_mixed();
        logic [15:0] lf = 16'hACE1;
        for (int k = 0; k < 300; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0], lf[1], lf[10:2], "R2 R3 R4 R5 R6 mixed");
        end
    endtask

    task automatic t_reset_mid();
        step(0, 0, 9'h1FF, "R2 preset");
        inc_req = 1'b1; dec_req = 1'b0;
        t_reset();
        step(1, 0, 9'd0, "R1 R3 count from cleared state");
    endtask

    initial begin
        #50000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        t_load();
        t_inc();
        t_dec();
        t_hold();
        t_edges();
        t_mixed();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule